// File: doc/BRIEF.md
# Configuration Frame Scrubbing Controller

This block keeps a frame-organised configuration memory free of accumulated single-event upsets. It talks to the memory through a request/valid frame port. A request carries a frame address, a word index, a write enable and write data, and it is accepted in any cycle where the port's busy input is low. Read data comes back on a separate valid strobe. A frame is a fixed number of data words followed by one check word. The controller rebuilds a single-error-correct, double-error-detect syndrome from the whole frame, one word at a time, while it copies the frame into a local buffer.

The block has two scan tiers. A cheap run scan only polls the memory's accumulated "some frame is bad" flag and makes no frame traffic. A locating walk reads every frame in address order and classifies each one. When the walk finds a frame with one located bit in error, it replays the frame from the buffer with that bit inverted. When the error cannot be located, the walk rewrites only the frame's check word so that the frame is no longer flagged. Each located error produces a status record. After reset the block makes one walk and then settles into run scans. Any raised error flag sends it back into a walk.

Top module: `cfg_scrub_ctrl`

## Requirements
- R1: While rst_ni is low, req_o and stat_valid_o are low and scan_mode_o is 0 (initialisation).
- R2: After reset the block makes exactly one walk (scan_mode_o = 1). The walk reads every word of every frame exactly once, in order: word 0 up to the check word, frame 0 up to the last frame. With no error present it issues no writes and no status records, and it then enters run scan (scan_mode_o = 2).
- R3: Code layout. Data bit b of data word w has position w*WORD_W+b+1. The check word is the last word of the frame: its bits [POS_W-1:0] hold the XOR of the positions of all set data bits, and bit POS_W holds the XOR of all data bits. The syndrome is {parity_error, position}. It is reported on stat_syn_o with parity_error as the MSB.
- R4: Classification. A zero position with parity OK is clean. A parity error with a position from 1 to the number of data bits is a single error. Every other syndrome, including a parity error with position 0, is uncorrectable.
- R5: For a single error the block emits a record with stat_class_o = 1, the frame address and the syndrome. It then writes all words of that frame back from the local buffer, with the located bit inverted and every other bit unchanged. The memory is not read again during the write-back.
- R6: For an uncorrectable error the block emits a record with class 2. It then makes exactly one write, to the check word, XORing the syndrome into it so that the frame's syndrome becomes clean. This write is followed by a record with class 3 and the same frame and syndrome. No data word is written.
- R7: In run scan the block issues no requests. When err_flag_i is high at a clock edge in run scan, it starts a walk from frame 0.
- R8: While busy_i is high, an outstanding request holds req_o, we_o, frame_o, word_o and wdata_o steady. Results are the same as with busy_i low.
- R9: Every walk ends in run scan, with all corrected or patched frames clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_flag_i | input | 1 | Memory's accumulated error indicator, polled in run scan |
| busy_i | input | 1 | Frame port stall; a request is accepted only when low |
| req_o | output | 1 | Frame port request |
| we_o | output | 1 | Request is a write |
| frame_o | output | FADDR_W | Frame address of the request |
| word_o | output | WIDX_W | Word index inside the frame |
| wdata_o | output | WORD_W | Write data |
| rvalid_i | input | 1 | Read data valid |
| rdata_i | input | WORD_W | Read data |
| scan_mode_o | output | 2 | 0 init, 1 walk, 2 run scan |
| stat_valid_o | output | 1 | One-cycle pulse per status record |
| stat_frame_o | output | FADDR_W | Frame address of the record |
| stat_syn_o | output | SYN_W | Syndrome {parity_error, position} |
| stat_class_o | output | 2 | 1 single corrected, 2 uncorrectable, 3 check word patched |

## Verification
The bench places single flips on the first and the last data bit of a frame, and in the first and the last frame of the array. These are the places where an off-by-one in position numbering or in the word/bit split would repair the neighbouring bit and leave the frame flagged. A double flip and a flip of the stored parity bit exercise the uncorrectable path. A design that wrote data words there, or picked the wrong class, would change data or loop in walks. The correction is repeated with a random stall on the frame port. A design that advanced its word index or changed write data while stalled would corrupt the replayed frame. The run scan is watched for stray frame traffic.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;
  typedef enum logic [1:0] {
    MODE_INIT = 2'd0,
    MODE_WALK = 2'd1,
    MODE_RUN  = 2'd2
  } scan_mode_e;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_SINGLE  = 2'd1,
    CLS_MULTI   = 2'd2,
    CLS_PATCHED = 2'd3
  } err_class_e;

  typedef enum logic [2:0] {
    ST_INIT, ST_RD, ST_RWAIT, ST_CLASS, ST_WB, ST_PATCH, ST_NEXT, ST_RUN
  } scrub_state_e;
endpackage

// File: rtl/cfg_scrub_syn.sv
module cfg_scrub_syn #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int POS_W       = 11,
  parameter int WIDX_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              perr_o
);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int ECC_IDX = FRAME_WORDS - 1;

  logic [POS_W-1:0] base, word_pos;
  logic             word_par;

  always_comb begin
    base     = POS_W'({widx_i, {BIT_W{1'b0}}});
    word_pos = '0;
    word_par = ^data_i;
    if (widx_i == WIDX_W'(ECC_IDX)) begin
      word_pos = data_i[POS_W-1:0];
      word_par = data_i[POS_W];
    end else begin
      for (int b = 0; b < WORD_W; b++) begin
        if (data_i[b]) word_pos = word_pos ^ (base + POS_W'(b + 1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      perr_o <= 1'b0;
    end else if (clr_i) begin
      pos_o  <= '0;
      perr_o <= 1'b0;
    end else if (en_i) begin
      pos_o  <= pos_o ^ word_pos;
      perr_o <= perr_o ^ word_par;
    end
  end
endmodule

// File: rtl/cfg_scrub_fbuf.sv
module cfg_scrub_fbuf #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int WIDX_W      = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WIDX_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WIDX_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [FRAME_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
  import cfg_scrub_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 41,
  parameter int NUM_FRAMES  = 8,
  localparam int DATA_BITS  = (FRAME_WORDS - 1) * WORD_W,
  localparam int POS_W      = $clog2(DATA_BITS + 1),
  localparam int SYN_W      = POS_W + 1,
  localparam int WIDX_W     = $clog2(FRAME_WORDS),
  localparam int FADDR_W    = $clog2(NUM_FRAMES > 1 ? NUM_FRAMES : 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               err_flag_i,
  input  logic               busy_i,
  output logic               req_o,
  output logic               we_o,
  output logic [FADDR_W-1:0] frame_o,
  output logic [WIDX_W-1:0]  word_o,
  output logic [WORD_W-1:0]  wdata_o,
  input  logic               rvalid_i,
  input  logic [WORD_W-1:0]  rdata_i,
  output logic [1:0]         scan_mode_o,
  output logic               stat_valid_o,
  output logic [FADDR_W-1:0] stat_frame_o,
  output logic [SYN_W-1:0]   stat_syn_o,
  output logic [1:0]         stat_class_o
);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int ECC_IDX = FRAME_WORDS - 1;

  scrub_state_e       state_q;
  logic [FADDR_W-1:0] frame_q;
  logic [WIDX_W-1:0]  word_q, fix_word_q;
  logic [BIT_W-1:0]   fix_bit_q;

  logic [POS_W-1:0]   syn_pos, fix_idx;
  logic               syn_perr, syn_clr, syn_en;
  logic               is_clean, is_single, last_word, last_frame;
  logic [WORD_W-1:0]  buf_rdata;

  assign syn_clr = (state_q == ST_INIT) || (state_q == ST_NEXT) || (state_q == ST_RUN);
  assign syn_en  = (state_q == ST_RWAIT) && rvalid_i;

  cfg_scrub_syn #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .POS_W(POS_W), .WIDX_W(WIDX_W)
  ) u_syn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (syn_clr),
    .en_i   (syn_en),
    .widx_i (word_q),
    .data_i (rdata_i),
    .pos_o  (syn_pos),
    .perr_o (syn_perr)
  );

  cfg_scrub_fbuf #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .WIDX_W(WIDX_W)
  ) u_fbuf (
    .clk_i   (clk_i),
    .we_i    (syn_en),
    .waddr_i (word_q),
    .wdata_i (rdata_i),
    .raddr_i (word_q),
    .rdata_o (buf_rdata)
  );

  assign is_clean   = (syn_pos == '0) && !syn_perr;
  assign is_single  = syn_perr && (syn_pos != '0) && (syn_pos <= POS_W'(DATA_BITS));
  assign fix_idx    = syn_pos - POS_W'(1);
  assign last_word  = (word_q == WIDX_W'(ECC_IDX));
  assign last_frame = (frame_q == FADDR_W'(NUM_FRAMES - 1));

  // frame port
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (state_q)
      ST_RD:    req_o = 1'b1;
      ST_WB: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = buf_rdata ^ ((word_q == fix_word_q) ? (WORD_W'(1) << fix_bit_q) : '0);
      end
      ST_PATCH: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = buf_rdata ^ WORD_W'({syn_perr, syn_pos});
      end
      default: ;
    endcase
  end

  assign frame_o = frame_q;
  assign word_o  = word_q;

  always_comb begin
    unique case (state_q)
      ST_INIT: scan_mode_o = MODE_INIT;
      ST_RUN:  scan_mode_o = MODE_RUN;
      default: scan_mode_o = MODE_WALK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_INIT;
      frame_q      <= '0;
      word_q       <= '0;
      fix_word_q   <= '0;
      fix_bit_q    <= '0;
      stat_valid_o <= 1'b0;
      stat_frame_o <= '0;
      stat_syn_o   <= '0;
      stat_class_o <= CLS_NONE;
    end else begin
      stat_valid_o <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          frame_q <= '0;
          word_q  <= '0;
          state_q <= ST_RD;
        end
        ST_RD: if (!busy_i) state_q <= ST_RWAIT;
        ST_RWAIT: if (rvalid_i) begin
          if (last_word) state_q <= ST_CLASS;
          else begin
            word_q  <= word_q + WIDX_W'(1);
            state_q <= ST_RD;
          end
        end
        ST_CLASS: begin
          if (is_clean) state_q <= ST_NEXT;
          else begin
            stat_valid_o <= 1'b1;
            stat_frame_o <= frame_q;
            stat_syn_o   <= {syn_perr, syn_pos};
            if (is_single) begin
              stat_class_o <= CLS_SINGLE;
              fix_word_q   <= WIDX_W'(fix_idx >> BIT_W);
              fix_bit_q    <= fix_idx[BIT_W-1:0];
              word_q       <= '0;
              state_q      <= ST_WB;
            end else begin
              stat_class_o <= CLS_MULTI;
              word_q       <= WIDX_W'(ECC_IDX);
              state_q      <= ST_PATCH;
            end
          end
        end
        ST_WB: if (!busy_i) begin
          if (last_word) state_q <= ST_NEXT;
          else word_q <= word_q + WIDX_W'(1);
        end
        ST_PATCH: if (!busy_i) begin
          stat_valid_o <= 1'b1;
          stat_class_o <= CLS_PATCHED;
          state_q      <= ST_NEXT;
        end
        ST_NEXT: begin
          word_q <= '0;
          if (last_frame) begin
            frame_q <= '0;
            state_q <= ST_RUN;
          end else begin
            frame_q <= frame_q + FADDR_W'(1);
            state_q <= ST_RD;
          end
        end
        ST_RUN: if (err_flag_i) begin
          frame_q <= '0;
          word_q  <= '0;
          state_q <= ST_RD;
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_scrub_ctrl_chk.sv
module cfg_scrub_ctrl_chk #(
  parameter int FRAME_WORDS = 41,
  parameter int NUM_FRAMES  = 8,
  parameter int WORD_W      = 32,
  parameter int FADDR_W     = 3,
  parameter int WIDX_W      = 6,
  parameter int SYN_W       = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_i,
  input logic               req_o,
  input logic               we_o,
  input logic [FADDR_W-1:0] frame_o,
  input logic [WIDX_W-1:0]  word_o,
  input logic [WORD_W-1:0]  wdata_o,
  input logic [1:0]         scan_mode_o,
  input logic               stat_valid_o,
  input logic [SYN_W-1:0]   stat_syn_o,
  input logic [1:0]         stat_class_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!req_o && !stat_valid_o && scan_mode_o == 2'd0);
    end
  end

  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ({1'b0, word_o} < (WIDX_W + 1)'(FRAME_WORDS)) &&
              ({1'b0, frame_o} < (FADDR_W + 1)'(NUM_FRAMES)));

  // R4
  single_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_class_o == 2'd1) |->
      (stat_syn_o[SYN_W-1] && stat_syn_o[SYN_W-2:0] != '0));

  // R5
  class_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> stat_class_o != 2'd0);

  // R6
  write_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> scan_mode_o == 2'd1);

  // R7
  run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_mode_o == 2'd2 |-> !req_o);

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && busy_i) |=> req_o && $stable(we_o) && $stable(frame_o) &&
                          $stable(word_o) && $stable(wdata_o));
endmodule

bind cfg_scrub_ctrl cfg_scrub_ctrl_chk #(
  .FRAME_WORDS(FRAME_WORDS), .NUM_FRAMES(NUM_FRAMES), .WORD_W(WORD_W),
  .FADDR_W(FADDR_W), .WIDX_W(WIDX_W), .SYN_W(SYN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .req_o        (req_o),
  .we_o         (we_o),
  .frame_o      (frame_o),
  .word_o       (word_o),
  .wdata_o      (wdata_o),
  .scan_mode_o  (scan_mode_o),
  .stat_valid_o (stat_valid_o),
  .stat_syn_o   (stat_syn_o),
  .stat_class_o (stat_class_o)
);

// File: tb/cfg_scrub_ctrl_bench.sv
module cfg_scrub_ctrl_bench;
  localparam int WORD_W     = 32;
  localparam int FRAME_WORDS = 41;
  localparam int NUM_FRAMES = 8;
  localparam int DATA_WORDS = FRAME_WORDS - 1;
  localparam int DATA_BITS  = DATA_WORDS * WORD_W;
  localparam int POS_W      = $clog2(DATA_BITS + 1);
  localparam int SYN_W      = POS_W + 1;
  localparam int WIDX_W     = $clog2(FRAME_WORDS);
  localparam int FADDR_W    = $clog2(NUM_FRAMES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_flag = 1'b0, busy = 1'b0, rvalid = 1'b0;
  logic [WORD_W-1:0] rdata = '0;
  logic req, we, stat_valid;
  logic [FADDR_W-1:0] frame, stat_frame;
  logic [WIDX_W-1:0]  word;
  logic [WORD_W-1:0]  wdata;
  logic [1:0]         mode, stat_class;
  logic [SYN_W-1:0]   stat_syn;

  always #5 clk = ~clk;

  cfg_scrub_ctrl #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .NUM_FRAMES(NUM_FRAMES))
  u_cfg_scrub_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .err_flag_i(err_flag), .busy_i(busy),
    .req_o(req), .we_o(we), .frame_o(frame), .word_o(word), .wdata_o(wdata),
    .rvalid_i(rvalid), .rdata_i(rdata), .scan_mode_o(mode),
    .stat_valid_o(stat_valid), .stat_frame_o(stat_frame), .stat_syn_o(stat_syn),
    .stat_class_o(stat_class)
  );

  int tests = 0, fails = 0;
  logic [WORD_W-1:0] mem [NUM_FRAMES][FRAME_WORDS];
  int mem_gen = 0, seen_gen = -1;
  int rd_cnt = 0, wr_cnt = 0, dwr_cnt = 0, rec_n = 0;
  bit order_bad = 0, saw_walk = 0;
  int last_f = -1, last_w = -1;
  logic [FADDR_W-1:0] rec_frame [32];
  logic [SYN_W-1:0]   rec_syn [32];
  logic [1:0]         rec_cls [32];
  logic inj_req = 1'b0;
  int inj_f = 0, inj_w = 0;
  logic [WORD_W-1:0] inj_mask = '0;
  logic busy_mode = 1'b0;
  logic [15:0] lfsr;

  function automatic logic [WORD_W-1:0] gold(int f, int w);
    logic [POS_W-1:0] p;
    logic par;
    logic [WORD_W-1:0] d;
    if (w < DATA_WORDS) return (32'h9E3779B9 * 32'(f * FRAME_WORDS + w + 1)) ^ 32'h5A5A0000;
    p = '0; par = 1'b0;
    for (int ww = 0; ww < DATA_WORDS; ww++) begin
      d = gold(f, ww);
      for (int b = 0; b < WORD_W; b++)
        if (d[b]) begin p ^= POS_W'(ww * WORD_W + b + 1); par ^= 1'b1; end
    end
    return WORD_W'({par, p});
  endfunction

  function automatic logic [SYN_W-1:0] frame_syn(int f);
    logic [POS_W-1:0] p;
    logic par;
    p = '0; par = 1'b0;
    for (int ww = 0; ww < DATA_WORDS; ww++)
      for (int b = 0; b < WORD_W; b++)
        if (mem[f][ww][b]) begin p ^= POS_W'(ww * WORD_W + b + 1); par ^= 1'b1; end
    p ^= mem[f][DATA_WORDS][POS_W-1:0];
    par ^= mem[f][DATA_WORDS][POS_W];
    return {par, p};
  endfunction

  // memory model and monitors
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FRAMES; f++)
        for (int w = 0; w < FRAME_WORDS; w++) mem[f][w] <= gold(f, w);
      rvalid <= 1'b0;
      mem_gen <= mem_gen + 1;
    end else begin
      rvalid <= req && !we && !busy;
      rdata  <= mem[frame][word];
      if (mode == 2'd1) saw_walk <= 1;
      if (req && !busy) begin
        if (we) begin
          mem[frame][word] <= wdata;
          wr_cnt <= wr_cnt + 1;
          if (int'(word) < DATA_WORDS) dwr_cnt <= dwr_cnt + 1;
          mem_gen <= mem_gen + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
          if (!((int'(frame) == last_f && int'(word) == last_w + 1) ||
                (int'(frame) == last_f + 1 && word == 0) ||
                (frame == 0 && word == 0)))
            order_bad <= 1;
          last_f <= int'(frame);
          last_w <= int'(word);
        end
      end
      if (inj_req) begin
        mem[inj_f][inj_w] <= mem[inj_f][inj_w] ^ inj_mask;
        mem_gen <= mem_gen + 1;
      end
      if (stat_valid && rec_n < 32) begin
        rec_frame[rec_n] <= stat_frame;
        rec_syn[rec_n]   <= stat_syn;
        rec_cls[rec_n]   <= stat_class;
        rec_n <= rec_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busy <= busy_mode & lfsr[0];
    if (mem_gen != seen_gen) begin
      logic any;
      any = 1'b0;
      for (int f = 0; f < NUM_FRAMES; f++) if (frame_syn(f) != '0) any = 1'b1;
      err_flag <= any;
      seen_gen <= mem_gen;
    end
  end

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic wait_mode(input logic [1:0] m, input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (mode == m) begin ok = 1; break; end
    end
  endtask

  task automatic inject(input int f, input int w, input logic [WORD_W-1:0] m);
    @(negedge clk);
    inj_f = f; inj_w = w; inj_mask = m; inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
  endtask

  task automatic run_walk(input string tag);
    bit ok;
    wait_mode(2'd1, 50, ok);
    chk(ok, {tag, " R7 walk start"}, mode, 1);
    wait_mode(2'd2, 20000, ok);
    chk(ok, {tag, " R9 back to run"}, mode, 2);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req == 1'b0, "R1 req", req, 0);
    chk(stat_valid == 1'b0, "R1 stat_valid", stat_valid, 0);
    chk(mode == 2'd0, "R1 mode", mode, 0);
  endtask

  task automatic t_startup;
    bit ok;
    wait_mode(2'd2, 20000, ok);
    chk(ok, "R2 reaches run", mode, 2);
    chk(saw_walk, "R2 walk seen", saw_walk, 1);
    chk(rd_cnt == NUM_FRAMES * FRAME_WORDS, "R2 read count", rd_cnt, NUM_FRAMES * FRAME_WORDS);
    chk(!order_bad, "R2 read order", order_bad, 0);
    chk(wr_cnt == 0, "R2 no writes", wr_cnt, 0);
    chk(rec_n == 0, "R2 no records", rec_n, 0);
  endtask

  task automatic t_run_idle;
    int r0 = rd_cnt;
    repeat (300) @(negedge clk);
    chk(rd_cnt == r0, "R7 no reads in run", rd_cnt - r0, 0);
    chk(mode == 2'd2, "R7 stays run", mode, 2);
  endtask

  task automatic t_single(input int f, input int w, input int b, input string tag);
    int r0 = rec_n, w0 = wr_cnt, mism = 0;
    logic [SYN_W-1:0] es;
    es = {1'b1, POS_W'(w * WORD_W + b + 1)};
    inject(f, w, WORD_W'(1) << b);
    run_walk(tag);
    chk(rec_n == r0 + 1, {tag, " R5 one record"}, rec_n - r0, 1);
    chk(rec_cls[r0] == 2'd1, {tag, " R4 class single"}, rec_cls[r0], 1);
    chk(int'(rec_frame[r0]) == f, {tag, " R5 frame"}, rec_frame[r0], f);
    chk(rec_syn[r0] == es, {tag, " R3 syndrome"}, rec_syn[r0], es);
    chk(wr_cnt - w0 == FRAME_WORDS, {tag, " R5 write count"}, wr_cnt - w0, FRAME_WORDS);
    for (int ww = 0; ww < FRAME_WORDS; ww++) if (mem[f][ww] != gold(f, ww)) mism++;
    chk(mism == 0, {tag, " R5 frame restored"}, mism, 0);
    chk(err_flag == 1'b0, {tag, " R9 clean"}, err_flag, 0);
  endtask

  task automatic t_uncorr(input int f, input int w1, input int b1, input int w2, input int b2,
                          input logic [SYN_W-1:0] es, input string tag);
    int r0 = rec_n, w0 = wr_cnt, d0 = dwr_cnt, mism = 0;
    logic [WORD_W-1:0] e;
    inject(f, w1, WORD_W'(1) << b1);
    if (w2 >= 0) inject(f, w2, WORD_W'(1) << b2);
    run_walk(tag);
    chk(rec_n == r0 + 2, {tag, " R6 two records"}, rec_n - r0, 2);
    chk(rec_cls[r0] == 2'd2, {tag, " R4 class multi"}, rec_cls[r0], 2);
    chk(rec_cls[r0+1] == 2'd3, {tag, " R6 class patched"}, rec_cls[r0+1], 3);
    chk(int'(rec_frame[r0+1]) == f, {tag, " R6 frame"}, rec_frame[r0+1], f);
    chk(rec_syn[r0] == es && rec_syn[r0+1] == es, {tag, " R3 syndrome"}, rec_syn[r0], es);
    chk(wr_cnt - w0 == 1, {tag, " R6 single write"}, wr_cnt - w0, 1);
    chk(dwr_cnt == d0, {tag, " R6 no data write"}, dwr_cnt - d0, 0);
    for (int ww = 0; ww < DATA_WORDS; ww++) begin
      e = gold(f, ww);
      if (ww == w1) e ^= WORD_W'(1) << b1;
      if (ww == w2) e ^= WORD_W'(1) << b2;
      if (mem[f][ww] != e) mism++;
    end
    chk(mism == 0, {tag, " R6 data kept"}, mism, 0);
    chk(frame_syn(f) == '0, {tag, " R6 frame clean"}, frame_syn(f), 0);
    chk(err_flag == 1'b0, {tag, " R9 clean"}, err_flag, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_startup();
    t_run_idle();
    t_single(3, 5, 7, "mid");
    t_single(0, 0, 0, "first bit");
    t_single(NUM_FRAMES - 1, DATA_WORDS - 1, WORD_W - 1, "last bit");
    t_uncorr(2, 4, 1, 9, 30, {1'b0, POS_W'(4*WORD_W + 2) ^ POS_W'(9*WORD_W + 31)}, "double");
    t_uncorr(6, DATA_WORDS, POS_W, -1, 0, {1'b1, POS_W'(0)}, "parity bit");
    busy_mode = 1'b1;
    t_single(5, 20, 13, "R8 stalled");
    busy_mode = 1'b0;
    t_run_idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule